// File: doc/BRIEF.md
# Saturating trim-setting counter with stored preset

This block keeps the 7-bit code for a 128-step sink-current DAC that trims a display bias voltage. The control pin is decoded elsewhere into three single-cycle strobes: step up, step down and store. An enable input gates them. While enable is high, the strobes move the code one step at a time and clamp it at both ends. A store strobe copies the code into an external nonvolatile word through a request/busy handshake. While enable is low, the code follows the stored word. This lets the stored value be read back without a power cycle.

The nonvolatile word is one bit wider than the code. Its top bit marks the word as blank, so an erased part comes up at mid-scale and not at an end of the range. Comparator noise can produce one false pulse after power-up or after a write. For that reason the first counting strobe after reset, and the first after each completed write, is absorbed without effect.

Top module: `trim_setting_ctrl`

## Requirements
- R1: With enable high, no write in progress and no pending skip, a lone up strobe raises `setting_o` by one and a lone down strobe lowers it by one. The change is visible after the clock edge that samples the strobe.
- R2: An up strobe while `setting_o` is 127 leaves it at 127.
- R3: A down strobe while `setting_o` is 0 leaves it at 0.
- R4: On a reset edge, `setting_o` takes the stored word. The word is 8 bits. Bit 7 = 0 marks it valid, and bits 6:0 then give the code. Bit 7 = 1 marks it blank, and the code becomes 64.
- R5: While enable is low, `setting_o` takes the decoded stored word (as in R4) on every edge. Up, down and store strobes have no effect, and `nvm_wreq_o` stays low.
- R6: A store strobe with enable high and no write in progress raises `nvm_wreq_o` after the next edge, with `nvm_wdata_o` = {1'b0, setting}. The request stays high until `nvm_busy_i` is seen high. The write ends when `nvm_busy_i` is next seen low.
- R7: Up and down strobes that arrive from the store strobe until the write ends are dropped.
- R8: A store strobe that arrives while a write is in progress is dropped, so only one write request is issued.
- R9: The first lone up or down strobe after reset is consumed with no change to `setting_o`. The same holds for the first such strobe after each completed write.
- R10: Up and down together are ignored and do not consume a pending skip. A store strobe in the same cycle as an up or down strobe starts the write, and the count strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the stored word |
| enable_i | input | 1 | High allows counting and storing; low tracks the stored word |
| up_i | input | 1 | Single-cycle step-up strobe |
| down_i | input | 1 | Single-cycle step-down strobe |
| prog_i | input | 1 | Single-cycle store strobe |
| nvm_rdata_i | input | 8 | Stored word: bit 7 blank marker, bits 6:0 code |
| nvm_wdata_o | output | 8 | Word to store, held while a write is in progress |
| nvm_wreq_o | output | 1 | Write request, held until busy is seen |
| nvm_busy_i | input | 1 | Memory busy flag during an internal write |
| setting_o | output | 7 | Current code to the DAC |

## Verification
The hardest state to reach is a write in flight with a second store strobe and a count strobe arriving while busy is high. The stimulus also has to show that the pending skip re-arms when that write ends. The bench uses a memory stub with a 40-cycle write latency. It waits until busy is observed high, then injects the stray strobes. After busy falls, it checks that exactly one write landed, that the stored word holds the code captured at the strobe, and that the next up strobe is absorbed. Both clamps are reached by reloading a near-end value through the enable-low path rather than by stepping through the whole range.

// File: rtl/trim_pkg.sv
package trim_pkg;

    parameter int SET_W = 7;
    localparam int MEM_W = SET_W + 1;

    typedef logic [SET_W-1:0] setting_t;
    typedef logic [MEM_W-1:0] nvm_word_t;

    localparam setting_t SET_MAX = '1;
    localparam setting_t SET_MIN = '0;
    localparam setting_t SET_MID = setting_t'(1) << (SET_W - 1);

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_REQ  = 2'd1,
        WR_WAIT = 2'd2
    } wr_state_e;

    // Top bit of the stored word flags an unwritten (erased) word.
    function automatic setting_t nvm_decode(nvm_word_t w);
        if (w[MEM_W-1]) return SET_MID;
        return w[SET_W-1:0];
    endfunction

    function automatic nvm_word_t nvm_encode(setting_t s);
        return {1'b0, s};
    endfunction

    // Both strobes at once cancel out.
    function automatic step_e classify(logic up, logic dn);
        if (up && !dn) return STEP_UP;
        if (dn && !up) return STEP_DN;
        return STEP_NONE;
    endfunction

    function automatic setting_t sat_step(setting_t v, step_e s);
        case (s)
            STEP_UP: return (v == SET_MAX) ? v : v + setting_t'(1);
            STEP_DN: return (v == SET_MIN) ? v : v - setting_t'(1);
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/trim_wr_seq.sv
module trim_wr_seq
    import trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      prog,
    input  logic      busy,
    input  setting_t  count,
    output nvm_word_t wdata_o,
    output logic      wreq_o,
    output logic      locked_o,
    output logic      start_o,
    output logic      done_o
);

    wr_state_e state_q;
    nvm_word_t wdata_q;

    assign start_o  = en && prog && (state_q == WR_IDLE);
    assign done_o   = (state_q == WR_WAIT) && !busy;
    assign locked_o = (state_q != WR_IDLE);
    assign wreq_o   = (state_q == WR_REQ);
    assign wdata_o  = wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            wdata_q <= '0;
        end else begin
            case (state_q)
                WR_IDLE: if (start_o) begin
                    state_q <= WR_REQ;
                    wdata_q <= nvm_encode(count);
                end
                WR_REQ:  if (busy) state_q <= WR_WAIT;
                WR_WAIT: if (!busy) state_q <= WR_IDLE;
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WR_REQ && !busy) |=> wreq_o);

    // R6
    wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WR_REQ) |=> $stable(wdata_o));

    // R8
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WR_WAIT) |=> !wreq_o);

    // R5
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WR_IDLE && !en) |=> (state_q == WR_IDLE));

endmodule

// File: rtl/trim_counter.sv
module trim_counter
    import trim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  step_e    step,
    input  logic     lock,
    input  logic     prog_take,
    input  logic     wr_done,
    input  setting_t reload_val,
    output setting_t setting_o
);

    setting_t cnt_q;
    logic     skip_q;
    logic     step_ok;

    assign step_ok   = en && !lock && !prog_take && (step != STEP_NONE);
    assign setting_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= reload_val;
            skip_q <= 1'b1;
        end else begin
            if (!en) begin
                cnt_q <= reload_val;
            end else if (step_ok && !skip_q) begin
                cnt_q <= sat_step(cnt_q, step);
            end

            if (wr_done) begin
                skip_q <= 1'b1;
            end else if (step_ok) begin
                skip_q <= 1'b0;
            end
        end
    end

    // R2
    top_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q == SET_MAX) |=> (setting_o != SET_MIN));

    // R3
    floor_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q == SET_MIN) |=> (setting_o != SET_MAX));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && lock) |=> $stable(setting_o));

    // R9
    skip_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (en && skip_q && step != STEP_NONE) |=> $stable(setting_o));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step == STEP_NONE) |=> $stable(setting_o));

endmodule

// File: rtl/trim_setting_ctrl.sv
module trim_setting_ctrl
    import trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             up_i,
    input  logic             down_i,
    input  logic             prog_i,
    input  logic [MEM_W-1:0] nvm_rdata_i,
    output logic [MEM_W-1:0] nvm_wdata_o,
    output logic             nvm_wreq_o,
    input  logic             nvm_busy_i,
    output logic [SET_W-1:0] setting_o
);

    step_e    step;
    setting_t reload_val;
    setting_t cur_setting;
    logic     locked;
    logic     wr_start;
    logic     wr_done;

    assign step       = classify(up_i, down_i);
    assign reload_val = nvm_decode(nvm_rdata_i);
    assign setting_o  = cur_setting;

    trim_wr_seq u_wr (
        .clk      (clk),
        .rst      (rst),
        .en       (enable_i),
        .prog     (prog_i),
        .busy     (nvm_busy_i),
        .count    (cur_setting),
        .wdata_o  (nvm_wdata_o),
        .wreq_o   (nvm_wreq_o),
        .locked_o (locked),
        .start_o  (wr_start),
        .done_o   (wr_done)
    );

    trim_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en         (enable_i),
        .step       (step),
        .lock       (locked),
        .prog_take  (wr_start),
        .wr_done    (wr_done),
        .reload_val (reload_val),
        .setting_o  (cur_setting)
    );

    // R5
    disabled_track_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable_i && !nvm_wreq_o) |=> !(nvm_wreq_o && $rose(nvm_wreq_o)));

endmodule

// File: tb/trim_setting_ctrl_tb_top.sv
module trim_setting_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       up = 1'b0;
    logic       dn = 1'b0;
    logic       prog = 1'b0;
    logic [7:0] rdata;
    logic [7:0] wdata;
    logic       wreq;
    logic       busy;
    logic [6:0] setting;

    int vectors = 0;
    int miscompares = 0;

    // memory stub
    logic [7:0] mem_q = 8'h25;
    logic [7:0] wbuf = 8'h00;
    logic       busy_q = 1'b0;
    int         lat = 0;
    int         wr_cnt = 0;
    logic       poke_req = 1'b0;
    logic [7:0] poke_val = 8'h00;

    assign rdata = mem_q;
    assign busy  = busy_q;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (poke_req) mem_q <= poke_val;
        if (wreq && !busy_q) begin
            busy_q <= 1'b1;
            wbuf   <= wdata;
            lat    <= 40;
            wr_cnt <= wr_cnt + 1;
        end else if (busy_q) begin
            if (lat == 0) begin
                busy_q <= 1'b0;
                mem_q  <= wbuf;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    trim_setting_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (en),
        .up_i        (up),
        .down_i      (dn),
        .prog_i      (prog),
        .nvm_rdata_i (rdata),
        .nvm_wdata_o (wdata),
        .nvm_wreq_o  (wreq),
        .nvm_busy_i  (busy),
        .setting_o   (setting)
    );

    // scoreboard
    int    exp_v[$];
    string exp_tag[$];

    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_v.size() > 0) begin
                int    v;
                string t;
                v = exp_v.pop_front();
                t = exp_tag.pop_front();
                vectors++;
                if (int'(setting) != v) begin
                    miscompares++;
                    $display("FAIL %s: setting=%0d expected=%0d", t, setting, v);
                end
            end
        end
    end

    task automatic push(input int v, input string t);
        exp_v.push_back(v);
        exp_tag.push_back(t);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check(input int got, input int exp, input string t);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got=%0d expected=%0d", t, got, exp);
        end
    endtask

    task automatic pulse(input logic u, input logic d, input logic p);
        @(negedge clk);
        up = u; dn = d; prog = p;
        @(negedge clk);
        up = 1'b0; dn = 1'b0; prog = 1'b0;
    endtask

    task automatic poke(input logic [7:0] v);
        @(negedge clk);
        poke_val = v; poke_req = 1'b1;
        @(negedge clk);
        poke_req = 1'b0;
    endtask

    task automatic wait_write_end();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4 reset loads the valid stored word 0x25
        push(37, "R4");
        // R9 first step after reset absorbed
        pulse(1, 0, 0); push(37, "R9");
        // R1 normal steps
        pulse(1, 0, 0); push(38, "R1");
        pulse(0, 1, 0); push(37, "R1");
        // R10 simultaneous up/down ignored
        pulse(1, 1, 0); push(37, "R10");
        pulse(1, 0, 0); push(38, "R10");
        // R5 enable low follows memory, ignores strobes
        poke(8'h05);
        en = 1'b0;
        repeat (2) @(negedge clk);
        push(5, "R5");
        pulse(1, 0, 0); push(5, "R5");
        pulse(0, 0, 1);
        check(int'(wreq), 0, "R5");
        @(negedge clk);
        check(int'(wreq), 0, "R5");
        en = 1'b1;
        // R3 step to floor and try to go below
        for (int i = 4; i >= 0; i--) begin
            pulse(0, 1, 0); push(i, "R1");
        end
        pulse(0, 1, 0); push(0, "R3");
        // R6 store handshake
        pulse(0, 0, 1);
        check(int'(wreq), 1, "R6");
        check(int'(wdata), 8'h00, "R6");
        while (!busy) @(negedge clk);
        // R7 count during write dropped, R8 second store dropped
        pulse(1, 0, 0); push(0, "R7");
        pulse(0, 0, 1);
        check(int'(wreq), 0, "R8");
        wait_write_end();
        check(wr_cnt, 1, "R8");
        check(int'(mem_q), 8'h00, "R6");
        // R9 first step after write absorbed
        pulse(1, 0, 0); push(0, "R9");
        pulse(1, 0, 0); push(1, "R9");
        // R2 near top via reload
        poke(8'h7E);
        en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        push(126, "R5");
        pulse(1, 0, 0); push(127, "R1");
        pulse(1, 0, 0); push(127, "R2");
        // R10 store wins over same-cycle up
        pulse(1, 0, 1);
        check(int'(wreq), 1, "R10");
        check(int'(setting), 127, "R10");
        wait_write_end();
        check(int'(mem_q), 8'h7F, "R6");
        check(wr_cnt, 2, "R10");
        pulse(0, 1, 0); push(127, "R9");
        // R4 blank word gives mid-scale
        poke(8'hFF);
        en = 1'b0;
        repeat (2) @(negedge clk);
        push(64, "R4");
        en = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        push(64, "R4");
        pulse(1, 0, 0); push(64, "R9");
        pulse(1, 0, 0); push(65, "R1");
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule